// File: doc/BRIEF.md
# 16-bit PWM compare channel

This block is one compare channel of a counter array, running in pulse-width-modulation mode. It contains the shared free-running timebase counter, which advances by one on each timebase enable pulse, and a compare value that is as wide as the counter. The output pin is cleared when the counter wraps from its maximum to zero. It is set when the counter reaches the compare value. The compare value therefore sets the low time of each period, and the high time is the rest of the period. With the default 16-bit counter, the duty cycle is (65536 − compare) / 65536.

Software loads the compare value through an 8-bit write port, one half at a time, low half first. A low-half write turns the comparator off, and the matching high-half write turns it back on. A half-updated compare value can therefore never produce a match. A sticky match flag and a gated interrupt request let software time its updates to the match event.

Top module: `pwm16_channel`

## Requirements
- R1: After reset the count, output, match flag and interrupt request are all 0, the compare value is 0 and every control bit is 0.
- R2: The count advances by exactly one on each cycle where `tick` is 1, wraps from all ones to 0, and holds while `tick` is 0.
- R3: When control bits 0 (compare enable), 1 (PWM select) and 2 (wide select) are all 1, a tick that brings the count to the compare value sets the output to 1 in the next cycle.
- R4: A tick that wraps the count to 0 clears the output. If the compare value is 0 the match on the same tick wins and the output stays 1.
- R5: With compare value C, the output is 1 exactly while the count is at least C, which is 2^W − C ticks of each 2^W-tick period. C = 0 gives a constant 1 and C = all ones gives one tick.
- R6: A write to address 1 loads the low half of the compare value from `wr_data[HALF_W-1:0]` and clears the compare enable. A write to address 2 loads the high half and sets the compare enable. A new value takes effect only after the high write.
- R7: While the compare enable is 0 the output never rises. It falls at the next wrap and then stays 0.
- R8: If PWM select or wide select is 0, no match occurs: the output does not rise and the match flag is not set.
- R9: A match sets the match flag, which stays set until a write to address 3 with `wr_data[0]` = 0. Writing 1 there has no effect, and a match in the same cycle as a clearing write keeps the flag set.
- R10: `irq` is 1 exactly when the match flag, control bit 3 (match interrupt enable) and control bit 4 (channel interrupt enable) are all 1. A write to address 0 loads control bits 4:0 from `wr_data[4:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase enable pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 compare low, 2 compare high, 3 flag |
| wr_data | input | 8 | Write data |
| count | output | 2*HALF_W | Timebase counter value |
| pwm_out | output | 1 | PWM output |
| match_flag | output | 1 | Sticky match flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the channel with HALF_W = 2, which gives a 4-bit counter and a 16-tick period. With this size, every compare value from 0 to 15 can be swept through a complete period, and the output after each tick can be compared with the arithmetic rule count >= C. The small period also makes it cheap to place a tick at a chosen count. This is used to put a clearing flag write on the same tick as a match, to drop the comparator between the two half writes, and to step through each combination of mode bits and interrupt enables.

// File: rtl/pwm16_pkg.sv
package pwm16_pkg;

   localparam int DATA_W = 8;

   typedef enum logic [1:0] {
      REG_CTRL   = 2'd0,
      REG_CMP_LO = 2'd1,
      REG_CMP_HI = 2'd2,
      REG_FLAG   = 2'd3
   } reg_addr_e;

   // bit 0 is the compare enable, bit 4 the channel interrupt enable
   typedef struct packed {
      logic irq_en;
      logic match_ie;
      logic wide_sel;
      logic pwm_sel;
      logic cmp_en;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] next_count,
   output logic             ovf_evt
);

   logic [CNT_W-1:0] cnt_q;

   assign next_count = cnt_q + CNT_W'(1);
   assign ovf_evt    = tick & (&cnt_q);
   assign count      = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= next_count;
      end
   end

endmodule

// File: rtl/pwm_cmp_regs.sv
module pwm_cmp_regs
   import pwm16_pkg::*;
#(
   parameter int HALF_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [1:0]            wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic                  match_evt,
   output logic [2*HALF_W-1:0]   cmp_val,
   output ctrl_t                 ctrl,
   output logic                  flag
);

   ctrl_t ctrl_q;
   logic  flag_q;
   logic  unused_wr_bits;

   assign unused_wr_bits = ^wr_data[DATA_W-1:CTRL_W];

   // one storage half per address, low half at bit 0
   for (genvar h = 0; h < 2; h++) begin : g_half
      localparam logic [1:0] HALF_ADDR = (h == 0) ? REG_CMP_LO : REG_CMP_HI;
      logic [HALF_W-1:0] half_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            half_q <= '0;
         end else if (wr_en && (wr_addr == HALF_ADDR)) begin
            half_q <= wr_data[HALF_W-1:0];
         end
      end

      assign cmp_val[h*HALF_W +: HALF_W] = half_q;
   end

   // the half writes also drive the compare enable
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en) begin
         case (reg_addr_e'(wr_addr))
            REG_CTRL:   ctrl_q        <= ctrl_t'(wr_data[CTRL_W-1:0]);
            REG_CMP_LO: ctrl_q.cmp_en <= 1'b0;
            REG_CMP_HI: ctrl_q.cmp_en <= 1'b1;
            default:    ctrl_q        <= ctrl_q;
         endcase
      end
   end

   // a match outranks a clearing write
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (match_evt) begin
         flag_q <= 1'b1;
      end else if (wr_en && (wr_addr == REG_FLAG) && !wr_data[0]) begin
         flag_q <= 1'b0;
      end
   end

   assign ctrl = ctrl_q;
   assign flag = flag_q;

endmodule

// File: rtl/pwm_cmp_core.sv
module pwm_cmp_core
   import pwm16_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter bit SET_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] next_count,
   input  logic             ovf_evt,
   input  logic [CNT_W-1:0] cmp_val,
   input  ctrl_t            ctrl,
   output logic             match_evt,
   output logic             pwm_out
);

   logic active;
   logic out_q;

   assign active    = ctrl.cmp_en & ctrl.pwm_sel & ctrl.wide_sel;
   assign match_evt = tick & active & (next_count == cmp_val);

   if (SET_WINS) begin : g_set_first
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_q <= 1'b0;
         end else if (match_evt) begin
            out_q <= 1'b1;
         end else if (ovf_evt) begin
            out_q <= 1'b0;
         end
      end
   end else begin : g_clr_first
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_q <= 1'b0;
         end else if (ovf_evt) begin
            out_q <= 1'b0;
         end else if (match_evt) begin
            out_q <= 1'b1;
         end
      end
   end

   assign pwm_out = out_q;

endmodule

// File: rtl/pwm16_channel.sv
module pwm16_channel
   import pwm16_pkg::*;
#(
   parameter int HALF_W   = 8,
   parameter bit SET_WINS = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                wr_en,
   input  logic [1:0]          wr_addr,
   input  logic [7:0]          wr_data,
   output logic [2*HALF_W-1:0] count,
   output logic                pwm_out,
   output logic                match_flag,
   output logic                irq
);

   localparam int CNT_W = 2 * HALF_W;

   if ((HALF_W < 1) || (HALF_W > DATA_W)) begin : g_bad_half_w
      $error("HALF_W must lie between 1 and the write-data width");
   end

   if (CTRL_W > DATA_W) begin : g_bad_ctrl_w
      $error("control field wider than the write data");
   end

   logic [CNT_W-1:0] next_count;
   logic             ovf_evt;
   logic [CNT_W-1:0] cmp_val;
   ctrl_t            ctrl;
   logic             match_evt;

   pwm_timebase #(
      .CNT_W (CNT_W)
   ) u_timebase (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .count      (count),
      .next_count (next_count),
      .ovf_evt    (ovf_evt)
   );

   pwm_cmp_regs #(
      .HALF_W (HALF_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .match_evt (match_evt),
      .cmp_val   (cmp_val),
      .ctrl      (ctrl),
      .flag      (match_flag)
   );

   pwm_cmp_core #(
      .CNT_W    (CNT_W),
      .SET_WINS (SET_WINS)
   ) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .next_count (next_count),
      .ovf_evt    (ovf_evt),
      .cmp_val    (cmp_val),
      .ctrl       (ctrl),
      .match_evt  (match_evt),
      .pwm_out    (pwm_out)
   );

   assign irq = match_flag & ctrl.match_ie & ctrl.irq_en;

endmodule

// File: rtl/pwm16_channel_chk.sv
module pwm16_channel_chk
   import pwm16_pkg::*;
#(
   parameter int HALF_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                tick,
   input logic                wr_en,
   input logic [1:0]          wr_addr,
   input logic [7:0]          wr_data,
   input logic [2*HALF_W-1:0] count,
   input logic [2*HALF_W-1:0] cmp_val,
   input ctrl_t               ctrl,
   input logic                pwm_out,
   input logic                match_flag,
   input logic                irq
);

   localparam int CNT_W = 2 * HALF_W;

   logic mode_on;
   assign mode_on = ctrl.cmp_en & ctrl.pwm_sel & ctrl.wide_sel;

   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (count == $past(count) + CNT_W'(1)));

   // R2
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(count));

   // R3
   set_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode_on && ((count + CNT_W'(1)) == cmp_val)) |=> pwm_out);

   // R4
   clr_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (&count) && !(mode_on && (cmp_val == '0))) |=> !pwm_out);

   // R7
   no_rise_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_on |=> !$rose(pwm_out));

   // R6
   lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == REG_CMP_LO)) |=> !ctrl.cmp_en);

   // R6
   hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == REG_CMP_HI)) |=> ctrl.cmp_en);

   // R9
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match_flag && !(wr_en && (wr_addr == REG_FLAG) && !wr_data[0])) |=> match_flag);

   // R10
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> match_flag);

endmodule

bind pwm16_channel pwm16_channel_chk #(
   .HALF_W (HALF_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick       (tick),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .count      (count),
   .cmp_val    (cmp_val),
   .ctrl       (ctrl),
   .pwm_out    (pwm_out),
   .match_flag (match_flag),
   .irq        (irq)
);

// File: tb/pwm16_channel_tb.sv
`timescale 1ns/1ps
module pwm16_channel_tb;

   localparam int HW  = 2;
   localparam int W   = 2 * HW;
   localparam int PER = 1 << W;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_addr = 2'd0;
   logic [7:0]   wr_data = 8'd0;
   logic [W-1:0] count;
   logic         pwm_out;
   logic         match_flag;
   logic         irq;

   int checks = 0;
   int errors = 0;
   int mc = 0;

   always #4 clk = ~clk;

   pwm16_channel #(.HALF_W(HW)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .count      (count),
      .pwm_out    (pwm_out),
      .match_flag (match_flag),
      .irq        (irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      mc = (mc + 1) % PER;
   endtask

   task automatic wreg(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic load_cmp(input int c);
      wreg(1, c % (1 << HW));
      wreg(2, c >> HW);
   endtask

   // tick until the count has just wrapped to 0
   task automatic to_wrap();
      while (mc != PER - 1) step();
      step();
   endtask

   // full period after a wrap: returns number of high ticks
   task automatic period_highs(output int highs);
      highs = int'(pwm_out);
      for (int k = 1; k < PER; k++) begin
         step();
         highs += int'(pwm_out);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int highs;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 count", int'(count), 0);
      chk("R1 pwm_out", int'(pwm_out), 0);
      chk("R1 flag", int'(match_flag), 0);
      chk("R1 irq", int'(irq), 0);

      // R2 step, hold and wrap
      for (int i = 0; i < 5; i++) begin
         step();
         chk("R2 step", int'(count), mc);
      end
      repeat (4) @(negedge clk);
      chk("R2 hold", int'(count), mc);
      while (mc != PER - 1) step();
      chk("R2 at max", int'(count), PER - 1);
      step();
      chk("R2 wrap", int'(count), 0);
      chk("R1 output idle after reset controls", int'(pwm_out), 0);

      // R3/R4/R5 sweep every compare value
      wreg(0, 8'h06);
      for (int c = 0; c < PER; c++) begin
         load_cmp(c);
         to_wrap();
         chk("R4 after wrap", int'(pwm_out), (c == 0) ? 1 : 0);
         highs = int'(pwm_out);
         for (int k = 1; k < PER; k++) begin
            step();
            chk("R3 per tick", int'(pwm_out), (k >= c) ? 1 : 0);
            highs += int'(pwm_out);
         end
         chk("R5 high ticks", highs, PER - c);
      end
      chk("R9 flag set by match", int'(match_flag), 1);

      // R9 flag writes
      wreg(3, 1);
      chk("R9 write 1 ignored", int'(match_flag), 1);
      wreg(3, 0);
      chk("R9 write 0 clears", int'(match_flag), 0);
      load_cmp(5);
      while (mc != 4) step();
      @(negedge clk);
      tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'd0;
      @(negedge clk);
      tick = 1'b0; wr_en = 1'b0;
      mc = (mc + 1) % PER;
      chk("R9 match beats clear", int'(match_flag), 1);
      wreg(3, 0);
      step();
      chk("R9 stays clear without match", int'(match_flag), 0);

      // R10 interrupt gating
      wreg(0, 8'h1F);
      chk("R10 no flag", int'(irq), 0);
      while (mc != 4) step();
      step();
      chk("R10 flag set", int'(match_flag), 1);
      chk("R10 all enabled", int'(irq), 1);
      wreg(0, 8'h17);
      chk("R10 match ie off", int'(irq), 0);
      wreg(0, 8'h0F);
      chk("R10 irq en off", int'(irq), 0);
      wreg(0, 8'h1F);
      chk("R10 re-enabled", int'(irq), 1);
      wreg(3, 0);
      chk("R10 flag cleared", int'(irq), 0);

      // R6/R7 interlock
      wreg(0, 8'h07);
      to_wrap();
      period_highs(highs);
      chk("R6 running C=5", highs, PER - 5);
      chk("R7 high before low write", int'(pwm_out), 1);
      wreg(1, 0);
      step();
      chk("R7 falls at wrap", int'(pwm_out), 0);
      period_highs(highs);
      chk("R7 stays low", highs, 0);
      chk("R6 half value unused", int'(pwm_out), 0);
      wreg(2, 1);
      to_wrap();
      period_highs(highs);
      chk("R6 new value after high write", highs, PER - (1 << HW));

      // R8 missing mode bits
      wreg(3, 0);
      wreg(0, 8'h05);
      to_wrap();
      period_highs(highs);
      chk("R8 no pwm select", highs, 0);
      wreg(0, 8'h03);
      to_wrap();
      period_highs(highs);
      chk("R8 no wide select", highs, 0);
      chk("R8 flag not set", int'(match_flag), 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule